// File: doc/BRIEF.md
# Byte-Lane I/O Window Decoder

This block stands between a little-endian host I/O port and three internal register targets: a sixteen-word SCSI core bank, an eight-word DMA bank and a single bus/control word. The host can issue a 1-, 2- or 4-byte read or write at any byte offset inside a 128-byte window. The block decodes the offset into a target and a word index and presents one aligned 32-bit access on a shared target port.

A write that covers a whole aligned word goes straight to the target. Any narrower or unaligned write first fetches the current word and then writes back that word with the new bytes merged into their lanes, so each target only ever sees full-word writes. A read fetches the word, shifts it down by the byte offset and keeps only the requested bytes. Offsets that map to no target produce no strobe on the target port. Writes to them are dropped and reads of them return zero.

The controller has four states. IDLE accepts a request with `req_ready` high. IDLE→COMMIT is taken for an aligned full-word write. IDLE→FETCH is taken for every other request. FETCH→COMMIT is taken for a merging write and FETCH→REPLY for a read. COMMIT→IDLE and REPLY→IDLE close the operation.

Top module: `io_window_decoder`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid`, `tgt_rd` and `tgt_wr` are 0.
- R2: Offsets 0x00–0x3F select the core bank: `tgt_sel` = 0 and `tgt_idx` = offset>>2.
- R3: Offsets 0x40–0x5F select the DMA bank: `tgt_sel` = 1 and `tgt_idx` = (offset−0x40)>>2.
- R4: Offsets 0x70–0x73 select the bus/control word: `tgt_sel` = 2 and `tgt_idx` = 0.
- R5: A write to any other offset (0x60–0x6F, 0x74–0x7F) asserts neither `tgt_rd` nor `tgt_wr`.
- R6: A read of any other offset returns `rsp_rdata` = 0 and asserts no `tgt_rd`.
- R7: A write with size code 2 or 3 at offset bits [1:0] = 0 asserts `tgt_wr` for one cycle, in the first cycle after acceptance, with `tgt_wdata` equal to `req_wdata`, and asserts no `tgt_rd`. `req_ready` returns in the second cycle.
- R8: Any other mapped write asserts `tgt_rd` in the first cycle after acceptance and `tgt_wr` in the second. Byte lanes k to k+n−1 of `tgt_wdata` (k = offset bits [1:0]) carry bytes 0 to n−1 of `req_wdata`, and the other lanes keep the fetched word. Here n is the requested size truncated at the word boundary, n = min(size, 4−k).
- R9: A read asserts `rsp_valid` for one cycle, in the second cycle after acceptance. `rsp_rdata` holds fetched bytes k to k+n−1 in bytes 0 to n−1, and the upper bytes are zero.
- R10: `req_ready` is low from the cycle after acceptance until the operation completes, and `req_valid` is ignored while it is low. `req_ready` returns in the third cycle for every operation except that of R7.
- R11: `req_size` code 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request strobe, taken when `req_ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte offset in the window |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data, low bytes first |
| req_ready | output | 1 | Block idle and able to accept |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Aligned, masked read data |
| tgt_rd | output | 1 | Target word fetch strobe |
| tgt_wr | output | 1 | Target word write strobe |
| tgt_sel | output | 2 | Target select (0 core, 1 DMA, 2 control) |
| tgt_idx | output | 4 | Word index within the target |
| tgt_wdata | output | 32 | Full word to write |
| tgt_rdata | input | 32 | Current word of the selected target, same cycle |

## Verification
The bench builds the block with its default parameters: a 7-bit offset, 32-bit words, a 4-bit index and region limits of 64, 96 and 112. This makes every byte offset of the window small enough to sweep together with all four size codes. Each offset is written and then read back, so every decode boundary, every lane/size/truncation combination and every unmapped hole is reached. The bench also holds a second write request on the port through every busy cycle, which shows that the block ignores input while busy.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

    typedef enum logic [1:0] {
        TGT_CORE = 2'd0,
        TGT_DMA  = 2'd1,
        TGT_CTRL = 2'd2,
        TGT_NONE = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_COMMIT,
        ST_REPLY
    } state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/iowin_decode.sv
module iowin_decode
    import iowin_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int IDX_W       = 4,
    parameter int OFF_W       = 2,
    parameter int CORE_LIMIT  = 64,
    parameter int DMA_LIMIT   = 96,
    parameter int CTRL_OFFSET = 112
) (
    input  logic [ADDR_W-1:0] addr,
    output tgt_e              tgt,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] CORE_A = ADDR_W'(CORE_LIMIT);
    localparam logic [ADDR_W-1:0] DMA_A  = ADDR_W'(DMA_LIMIT);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFFSET);

    logic [ADDR_W-1:0] dma_rel;
    logic [ADDR_W-1:0] word_addr;

    assign dma_rel   = addr - CORE_A;
    assign word_addr = addr >> OFF_W;

    always_comb begin
        tgt = TGT_NONE;
        idx = '0;
        if (addr < CORE_A) begin
            tgt = TGT_CORE;
            idx = IDX_W'(word_addr);
        end else if (addr < DMA_A) begin
            tgt = TGT_DMA;
            idx = IDX_W'(dma_rel >> OFF_W);
        end else if (word_addr == (CTRL_A >> OFF_W)) begin
            tgt = TGT_CTRL;
        end
    end

endmodule

// File: rtl/iowin_lanes.sv
module iowin_lanes
    import iowin_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [$clog2(DATA_W/8)-1:0] off,
    input  logic [1:0]                  size_code,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [DATA_W-1:0]           word,
    output logic [DATA_W/8-1:0]         byte_en,
    output logic [DATA_W-1:0]           merged,
    output logic [DATA_W-1:0]           rdata
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);
    localparam int CNT_W = OFF_W + 1;

    logic [CNT_W-1:0]  want_n;
    logic [CNT_W-1:0]  room_n;
    logic [CNT_W-1:0]  eff_n;
    logic [DATA_W-1:0] wdata_sh;
    logic [DATA_W-1:0] word_sh;

    // requested byte count, truncated where the word ends
    always_comb begin
        unique case (size_code)
            SZ_BYTE: want_n = CNT_W'(1);
            SZ_HALF: want_n = CNT_W'(2);
            default: want_n = CNT_W'(LANES);
        endcase
        room_n = CNT_W'(LANES) - {1'b0, off};
        eff_n  = (want_n < room_n) ? want_n : room_n;
    end

    assign wdata_sh = wdata << {off, 3'b000};
    assign word_sh  = word >> {off, 3'b000};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign byte_en[g] = (CNT_W'(g) >= {1'b0, off}) &&
                            (CNT_W'(g) < ({1'b0, off} + eff_n));
        assign merged[8*g +: 8] = byte_en[g] ? wdata_sh[8*g +: 8] : word[8*g +: 8];
        assign rdata[8*g +: 8]  = (CNT_W'(g) < eff_n) ? word_sh[8*g +: 8] : 8'h00;
    end

endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
    import iowin_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 32,
    parameter int IDX_W       = 4,
    parameter int CORE_LIMIT  = 64,
    parameter int DMA_LIMIT   = 96,
    parameter int CTRL_OFFSET = 112
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              tgt_rd,
    output logic              tgt_wr,
    output logic [1:0]        tgt_sel,
    output logic [IDX_W-1:0]  tgt_idx,
    output logic [DATA_W-1:0] tgt_wdata,
    input  logic [DATA_W-1:0] tgt_rdata
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    state_e            state_q, state_nx;
    logic              wr_q;
    tgt_e              tgt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [OFF_W-1:0]  off_q;
    logic [1:0]        size_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] word_q;

    tgt_e              dec_tgt;
    logic [IDX_W-1:0]  dec_idx;
    logic [LANES-1:0]  lane_en;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] aligned;
    logic              accept;
    logic              whole_word;

    iowin_decode #(
        .ADDR_W     (ADDR_W),
        .IDX_W      (IDX_W),
        .OFF_W      (OFF_W),
        .CORE_LIMIT (CORE_LIMIT),
        .DMA_LIMIT  (DMA_LIMIT),
        .CTRL_OFFSET(CTRL_OFFSET)
    ) u_dec (
        .addr(req_addr),
        .tgt (dec_tgt),
        .idx (dec_idx)
    );

    iowin_lanes #(
        .DATA_W(DATA_W)
    ) u_lanes (
        .off      (off_q),
        .size_code(size_q),
        .wdata    (wdata_q),
        .word     (word_q),
        .byte_en  (lane_en),
        .merged   (merged),
        .rdata    (aligned)
    );

    assign accept     = (state_q == ST_IDLE) && req_valid;
    assign whole_word = req_write && (req_size >= SZ_WORD) &&
                        (req_addr[OFF_W-1:0] == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_nx = whole_word ? ST_COMMIT : ST_FETCH;
            ST_FETCH:  state_nx = wr_q ? ST_COMMIT : ST_REPLY;
            ST_COMMIT: state_nx = ST_IDLE;
            ST_REPLY:  state_nx = ST_IDLE;
        endcase
    end

    // request capture and word fetch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            tgt_q   <= TGT_NONE;
            idx_q   <= '0;
            off_q   <= '0;
            size_q  <= SZ_BYTE;
            wdata_q <= '0;
            word_q  <= '0;
        end else begin
            if (accept) begin
                wr_q    <= req_write;
                tgt_q   <= dec_tgt;
                idx_q   <= dec_idx;
                off_q   <= req_addr[OFF_W-1:0];
                size_q  <= req_size;
                wdata_q <= req_wdata;
            end
            if (state_q == ST_FETCH) begin
                word_q <= (tgt_q != TGT_NONE) ? tgt_rdata : '0;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        tgt_rd    = (state_q == ST_FETCH)  && (tgt_q != TGT_NONE);
        tgt_wr    = (state_q == ST_COMMIT) && (tgt_q != TGT_NONE);
        tgt_sel   = tgt_q;
        tgt_idx   = idx_q;
        tgt_wdata = merged;
        rsp_valid = (state_q == ST_REPLY);
        rsp_rdata = (state_q == ST_REPLY) ? aligned : '0;
    end

    // R10: accepted request makes the block busy on the next cycle
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R5: target strobes only for a mapped target
    a_r5_strobe_mapped: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_rd || tgt_wr) |-> (tgt_sel != TGT_NONE));

    // R7: a target write lasts one cycle and ends the operation
    a_r7_write_single: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_wr |=> (!tgt_wr && req_ready));

    // R9: a reply lasts one cycle and ends the operation
    a_r9_reply_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R8: a fetch is followed by a write or a reply to the same word
    a_r8_fetch_followed: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rd |=> ((tgt_wr || rsp_valid) && $stable(tgt_sel) && $stable(tgt_idx)));

    // R8: every forwarded write carries at least one new byte lane
    a_r8_lanes_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_wr |-> ($countones(lane_en) > 0));

endmodule

// File: tb/sim_io_window_decoder.sv
module sim_io_window_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, tgt_rd, tgt_wr;
    logic [31:0] rsp_rdata, tgt_wdata;
    logic [31:0] tgt_rdata;
    logic [1:0]  tgt_sel;
    logic [3:0]  tgt_idx;

    logic [31:0] mem [25];
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    io_window_decoder u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .tgt_rd(tgt_rd), .tgt_wr(tgt_wr), .tgt_sel(tgt_sel), .tgt_idx(tgt_idx),
        .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata)
    );

    function automatic int slot_of(input int sel, input int idx);
        if (sel == 0) return idx & 15;
        if (sel == 1) return 16 + (idx & 7);
        return 24;
    endfunction

    // target model: combinational read, write on the clock edge
    always_comb begin
        if (tgt_sel == 2'd3) tgt_rdata = 32'hFFFF_FFFF;
        else                 tgt_rdata = mem[slot_of(int'(tgt_sel), int'(tgt_idx))];
    end

    always @(posedge clk) begin
        if (tgt_wr && tgt_sel != 2'd3) mem[slot_of(int'(tgt_sel), int'(tgt_idx))] <= tgt_wdata;
    end

    task automatic chk(input bit ok, input string tag, input int a,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h", tag, a, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic run_access(input bit wr, input int a, input int sz, input logic [31:0] wd);
        int kind, idx, off, nb, n, slot, c, rd_c, wr_c, rsp_c, rdy_c, nrd, nwr, nrsp, exp_rdy;
        logic [31:0] old, expw, expr, wr_d, rsp_d;
        logic [1:0] wr_s, rd_s;
        logic [3:0] wr_i, rd_i;
        bit full;
        string kt, dt;
        // expected decode (R2, R3, R4)
        if (a < 64)                   begin kind = 0; idx = a >> 2; end
        else if (a < 96)              begin kind = 1; idx = (a - 64) >> 2; end
        else if (a >= 112 && a < 116) begin kind = 2; idx = 0; end
        else                          begin kind = 3; idx = 0; end
        kt = (kind == 0) ? "R2" : (kind == 1) ? "R3" : "R4";
        off  = a & 3;
        nb   = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;  // R11
        n    = (nb < 4 - off) ? nb : 4 - off;
        full = wr && sz >= 2 && off == 0;
        slot = slot_of(kind, idx);
        old  = (kind < 3) ? mem[slot] : 32'h0;
        expw = old;
        expr = 32'h0;
        for (int b = 0; b < n; b++) begin
            expw[8*(off+b) +: 8] = wd[8*b +: 8];
            expr[8*b +: 8]       = old[8*(off+b) +: 8];
        end
        dt = (sz == 3) ? "R11" : (full ? "R7" : (wr ? "R8" : "R9"));
        exp_rdy = full ? 2 : 3;

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = 7'(a);
        req_size = 2'(sz); req_wdata = wd;
        @(negedge clk);
        // R10: a competing request is held on the port while busy
        req_write = 1'b1; req_addr = 7'h3C; req_size = 2'd2; req_wdata = 32'hDEAD_BEEF;
        c = 1; rdy_c = 0; rd_c = 0; wr_c = 0; rsp_c = 0; nrd = 0; nwr = 0; nrsp = 0;
        wr_d = '0; rsp_d = '0; wr_s = '0; rd_s = '0; wr_i = '0; rd_i = '0;
        while (rdy_c == 0 && c < 10) begin
            if (tgt_rd)    begin nrd++;  rd_c = c;  rd_s = tgt_sel; rd_i = tgt_idx; end
            if (tgt_wr)    begin nwr++;  wr_c = c;  wr_s = tgt_sel; wr_i = tgt_idx; wr_d = tgt_wdata; end
            if (rsp_valid) begin nrsp++; rsp_c = c; rsp_d = rsp_rdata; end
            if (req_ready) begin rdy_c = c; req_valid = 1'b0; end
            else begin c++; @(negedge clk); end
        end
        req_valid = 1'b0;

        chk(rdy_c == exp_rdy, full ? "R7" : "R10", a, 32'(rdy_c), 32'(exp_rdy));
        if (wr) begin
            if (kind < 3) begin
                chk(nwr == 1 && wr_c == (full ? 1 : 2), full ? "R7" : "R8", a, 32'(wr_c), full ? 1 : 2);
                chk(wr_s == 2'(kind) && wr_i == 4'(idx), kt, a, {wr_s, wr_i}, {2'(kind), 4'(idx)});
                chk(wr_d == expw, dt, a, wr_d, expw);
                chk(mem[slot] == expw, dt, a, mem[slot], expw);
                if (full) chk(nrd == 0, "R7", a, 32'(nrd), 0);
                else      chk(nrd == 1 && rd_c == 1, "R8", a, 32'(rd_c), 1);
            end else begin
                chk(nwr == 0 && nrd == 0, "R5", a, 32'(nwr + nrd), 0);
            end
        end else begin
            chk(nrsp == 1 && rsp_c == 2, "R9", a, 32'(rsp_c), 2);
            chk(rsp_d == expr, (kind < 3) ? dt : "R6", a, rsp_d, expr);
            if (kind < 3)
                chk(nrd == 1 && rd_s == 2'(kind) && rd_i == 4'(idx), kt, a, {rd_s, rd_i}, {2'(kind), 4'(idx)});
            else
                chk(nrd == 0 && nwr == 0, "R6", a, 32'(nrd + nwr), 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 25; i++) mem[i] = 32'h9E37_79B9 * 32'(i + 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(req_ready == 1'b1, "R1", 0, 32'(req_ready), 1);
        chk(rsp_valid == 1'b0 && tgt_rd == 1'b0 && tgt_wr == 1'b0, "R1", 0,
            {29'd0, rsp_valid, tgt_rd, tgt_wr}, 0);
        for (int sz = 0; sz < 4; sz++) begin
            for (int a = 0; a < 128; a++) begin
                logic [31:0] wd;
                wd = 32'h5A00_0000 ^ (32'(a) * 32'h0103_0507) ^ (32'(sz) << 12);
                run_access(1'b1, a, sz, wd);
                run_access(1'b0, a, sz, 32'h0);
            end
        end
        summary();
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
        $finish;
    end

endmodule